// File: doc/BRIEF.md
# PRBS-23 Serial Bit Stream Checker

This block watches a serial pseudo-random bit stream that arrives one bit per clock and tells whether the link carrying it is clean. It first synchronises an internal reference to the incoming pattern. After that it predicts every following bit and compares the prediction with what actually arrives. The sequence follows the recurrence x^23 + x^18 + 1, so the pattern repeats every 2^23 − 1 bits.

The checker drives a lock flag, a 64-bit count of bits received while locked and a 64-bit count of mismatching bits. It copes with an isolated bad bit without losing lock. It gives up lock when errors keep coming and then hunts for the pattern again with no outside help. A matching generator with an error-inject input is part of the project. It serves as the stimulus source and as the transmit side of a loopback.

Top module: `prbs23_checker`

## Requirements
- R1: While rst_n is low, locked is 0 and both counters are 0. locked is still 0 in the first cycle after rst_n is released.
- R2: In hunt mode the checker loads each received bit into a 23-bit history. It predicts the next bit as history[22] XOR history[17], the bits received 23 and 18 cycles earlier. locked goes high on the clock edge that completes 32 consecutive correct predictions, which comes well inside 2 × (2^23 − 1) cycles of a clean stream.
- R3: err_cnt changes only while locked is high. It is still 0 when lock is first reached on a clean stream, and it stays unchanged for as long as the checker is hunting.
- R4: word_cnt rises by exactly 1 at every clock edge where locked was high before the edge. It holds its value at every edge where locked was low.
- R5: Once locked, the reference runs free on its own predictions. A single corrupted bit therefore raises err_cnt by exactly 1 and leaves locked high.
- R6: While locked, every mismatch adds 1 to err_cnt. On the 16th consecutive mismatch locked falls, and that 16th mismatch is still counted. A burst of 15 consecutive mismatches followed by a correct bit keeps lock.
- R7: When a clean stream comes back after lock was lost, the checker locks again by itself, and after that it counts no errors.
- R8: The generator starts from a non-zero seed and puts out one bit per clock that follows the same recurrence. While its inject input is high, the bit it sends is the logical inverse of the true sequence bit. The true sequence itself is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_bit | input | 1 | Received serial bit |
| locked | output | 1 | High while the reference is synchronised to the stream |
| word_cnt | output | 64 | Number of bits received while locked |
| err_cnt | output | 64 | Number of mismatching bits received while locked |

## Verification
The assertions assume that reset is held long enough to clear every register. They also assume that the 64-bit counters never wrap within a run, and that rx_bit changes only just after a rising edge. The stimulus keeps within these limits. rx_bit always comes from the registered companion generator, corruption is applied only through its inject input, driven away from the clock edge, and each run lasts a few hundred cycles. The inject patterns cover a single bit, a burst that stops just short of the drop limit, and an unbroken run. The unbroken run also shows that an inverted stream can never be mistaken for the pattern.

// File: rtl/prbs23_pkg.sv
package prbs23_pkg;
  localparam int unsigned PRBS_ORDER = 23;
  localparam int unsigned PRBS_TAP   = 18;
  localparam int unsigned LOCK_GOOD  = 32;
  localparam int unsigned DROP_BAD   = 16;
  localparam int unsigned COUNT_W    = 64;

  typedef enum logic {
    TRK_HUNT   = 1'b0,
    TRK_LOCKED = 1'b1
  } trk_state_e;
endpackage

// File: rtl/prbs23_source.sv
module prbs23_source
  import prbs23_pkg::*;
#(
  parameter int unsigned ORDER = PRBS_ORDER,
  parameter int unsigned TAP   = PRBS_TAP,
  parameter logic [ORDER-1:0] SEED = 23'h5A5A5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inject,
  output logic tx_bit
);
  // an all-zero seed would freeze the sequence, so it is replaced
  localparam logic [ORDER-1:0] SEED_SAFE = (SEED == '0) ? {{(ORDER-1){1'b0}}, 1'b1} : SEED;

  logic [ORDER-1:0] lfsr_q, lfsr_d;
  logic             tx_q, tx_d;
  logic             fb;

  always_comb begin
    fb     = lfsr_q[ORDER-1] ^ lfsr_q[TAP-1];
    lfsr_d = {lfsr_q[ORDER-2:0], fb};
    tx_d   = fb ^ inject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED_SAFE;
      tx_q   <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_bit = tx_q;
endmodule

// File: rtl/prbs23_predictor.sv
module prbs23_predictor
  import prbs23_pkg::*;
#(
  parameter int unsigned ORDER = PRBS_ORDER,
  parameter int unsigned TAP   = PRBS_TAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic hunt,
  output logic pred_bit
);
  logic [ORDER-1:0] hist_q, hist_d;
  logic             shift_in;

  always_comb begin
    pred_bit = hist_q[ORDER-1] ^ hist_q[TAP-1];
    // hunting: follow the line; locked: run free on the prediction
    shift_in = hunt ? rx_bit : pred_bit;
    hist_d   = {hist_q[ORDER-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/prbs23_lock_ctrl.sv
module prbs23_lock_ctrl
  import prbs23_pkg::*;
#(
  parameter int unsigned LOCK_RUN = LOCK_GOOD,
  parameter int unsigned DROP_RUN = DROP_BAD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic pred_bit,
  output logic hunt,
  output logic locked,
  output logic err_inc,
  output logic word_inc
);
  localparam int unsigned GW = $clog2(LOCK_RUN);
  localparam int unsigned BW = $clog2(DROP_RUN);

  trk_state_e    state_q, state_d;
  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          miss;

  always_comb begin
    miss    = rx_bit ^ pred_bit;
    state_d = state_q;
    good_d  = good_q;
    bad_d   = bad_q;
    unique case (state_q)
      TRK_HUNT: begin
        if (miss) begin
          good_d = '0;
        end else if (good_q == GW'(LOCK_RUN - 1)) begin
          state_d = TRK_LOCKED;
          good_d  = '0;
          bad_d   = '0;
        end else begin
          good_d = good_q + GW'(1);
        end
      end
      TRK_LOCKED: begin
        if (miss) begin
          if (bad_q == BW'(DROP_RUN - 1)) begin
            state_d = TRK_HUNT;
            bad_d   = '0;
            good_d  = '0;
          end else begin
            bad_d = bad_q + BW'(1);
          end
        end else begin
          bad_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_HUNT;
      good_q  <= '0;
      bad_q   <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
      bad_q   <= bad_d;
    end
  end

  assign hunt     = (state_q == TRK_HUNT);
  assign locked   = (state_q == TRK_LOCKED);
  assign word_inc = locked;
  assign err_inc  = locked & miss;
endmodule

// File: rtl/prbs23_event_counter.sv
module prbs23_event_counter
  import prbs23_pkg::*;
#(
  parameter int unsigned W = COUNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/prbs23_checker.sv
module prbs23_checker
  import prbs23_pkg::*;
#(
  parameter int unsigned ORDER    = PRBS_ORDER,
  parameter int unsigned TAP      = PRBS_TAP,
  parameter int unsigned LOCK_RUN = LOCK_GOOD,
  parameter int unsigned DROP_RUN = DROP_BAD,
  parameter int unsigned CNT_W    = COUNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  output logic             locked,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  logic pred_bit;
  logic hunt;
  logic err_inc;
  logic word_inc;

  prbs23_predictor #(.ORDER(ORDER), .TAP(TAP)) u_pred (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .hunt(hunt), .pred_bit(pred_bit)
  );

  prbs23_lock_ctrl #(.LOCK_RUN(LOCK_RUN), .DROP_RUN(DROP_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .pred_bit(pred_bit),
    .hunt(hunt), .locked(locked), .err_inc(err_inc), .word_inc(word_inc)
  );

  prbs23_event_counter #(.W(CNT_W)) u_word_cnt (
    .clk(clk), .rst_n(rst_n), .inc(word_inc), .count(word_cnt)
  );

  prbs23_event_counter #(.W(CNT_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .inc(err_inc), .count(err_cnt)
  );
endmodule

// File: rtl/prbs23_checker_sva.sv
module prbs23_checker_sva #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic [CNT_W-1:0] word_cnt,
  input logic [CNT_W-1:0] err_cnt
);
  assert_hunt_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !locked);

  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (word_cnt == $past(word_cnt) + CNT_W'(1)));

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(word_cnt));

  assert_no_err_hunting_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(err_cnt));

  assert_err_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + CNT_W'(1))));

  assert_drop_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (err_cnt == $past(err_cnt) + CNT_W'(1)));
endmodule

bind prbs23_checker prbs23_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .locked(locked), .word_cnt(word_cnt), .err_cnt(err_cnt)
);

// File: tb/test_prbs23_checker.sv
module test_prbs23_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inject = 1'b0;
  logic        tx;
  logic        locked;
  logic [63:0] word_cnt;
  logic [63:0] err_cnt;
  bit          cmp_on = 1'b0;
  bit          ended = 1'b0;
  int          tests = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  prbs23_source i_prbs23_source (.clk(clk), .rst_n(rst_n), .inject(inject), .tx_bit(tx));

  prbs23_checker i_prbs23_checker (
    .clk(clk), .rst_n(rst_n), .rx_bit(tx), .locked(locked), .word_cnt(word_cnt), .err_cnt(err_cnt)
  );

  // behavioural reference: queues of bits and integer run counters
  bit              mq[$];
  bit              th[$];
  int              m_good, m_bad, rec_bad, rec_seen;
  bit              m_locked, inj_prev, gen_valid;
  longint unsigned m_word, m_err;

  always @(posedge clk) begin
    bit rx, pred, mis;
    if (!rst_n) begin
      mq = {};
      for (int i = 0; i < 23; i++) mq.push_back(1'b0);
      th = {};
      m_good = 0; m_bad = 0; m_locked = 0; m_word = 0; m_err = 0;
      gen_valid = 0; inj_prev = 0;
    end else begin
      rx   = tx;
      pred = mq[0] ^ mq[5];  // bits 23 and 18 cycles back
      mis  = rx ^ pred;
      if (!m_locked) begin
        mq.push_back(rx);
        if (mis) m_good = 0;
        else if (m_good == 31) begin m_locked = 1; m_good = 0; m_bad = 0; end
        else m_good++;
      end else begin
        m_word++;
        mq.push_back(pred);
        if (mis) begin
          m_err++;
          if (m_bad == 15) begin m_locked = 0; m_bad = 0; m_good = 0; end
          else m_bad++;
        end else m_bad = 0;
      end
      void'(mq.pop_front());
      // generator: undo the known inversion, then test the recurrence (R8)
      if (gen_valid) begin
        th.push_back(rx ^ inj_prev);
        if (th.size() > 23) begin
          rec_seen++;
          if (th[23] != (th[0] ^ th[5])) rec_bad++;
          void'(th.pop_front());
        end
      end
      gen_valid = 1;
      inj_prev  = inject;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !ended) begin
      tests++;
      if (locked !== m_locked || word_cnt !== m_word || err_cnt !== m_err) begin
        fails++;
        $display("FAIL R2 R3 R4 R5 R6 R7 per-cycle: locked=%0b exp %0b word=%0d exp %0d err=%0d exp %0d",
                 locked, m_locked, word_cnt, m_word, err_cnt, m_err);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint unsigned w0, e0;
    int n;
    rst_n = 1'b0;
    repeat (32) @(negedge clk);
    check(locked == 1'b0, "R1 locked in reset", 64'(locked), 0);
    check(word_cnt == 0, "R1 word_cnt in reset", word_cnt, 0);
    check(err_cnt == 0, "R1 err_cnt in reset", err_cnt, 0);
    rst_n  = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(locked == 1'b0, "R1 locked first cycle after reset", 64'(locked), 0);

    n = 0;
    while (!locked && n < 100) begin @(negedge clk); n++; end
    check(locked == 1'b1, "R2 lock on clean stream", 64'(locked), 1);
    check(err_cnt == 0, "R3 err_cnt at first lock", err_cnt, 0);

    w0 = word_cnt;
    repeat (50) @(negedge clk);
    check(word_cnt == w0 + 50, "R4 word_cnt while locked", word_cnt, w0 + 50);

    e0 = err_cnt;
    inject = 1'b1;
    @(negedge clk);
    inject = 1'b0;
    repeat (10) @(negedge clk);
    check(err_cnt == e0 + 1, "R5 single error counted once", err_cnt, e0 + 1);
    check(locked == 1'b1, "R5 lock kept after single error", 64'(locked), 1);

    e0 = err_cnt;
    inject = 1'b1;
    repeat (15) @(negedge clk);
    inject = 1'b0;
    repeat (10) @(negedge clk);
    check(err_cnt == e0 + 15, "R6 burst of 15 counted", err_cnt, e0 + 15);
    check(locked == 1'b1, "R6 lock kept after 15-bit burst", 64'(locked), 1);

    e0 = err_cnt;
    inject = 1'b1;
    n = 0;
    while (locked && n < 2000) begin @(negedge clk); n++; end
    check(locked == 1'b0, "R6 lock lost under constant errors", 64'(locked), 0);
    check(err_cnt == e0 + 16, "R6 errors up to the drop", err_cnt, e0 + 16);

    e0 = err_cnt;
    w0 = word_cnt;
    repeat (100) @(negedge clk);
    check(err_cnt == e0, "R3 no errors counted while hunting", err_cnt, e0);
    check(word_cnt == w0, "R4 word_cnt holds while hunting", word_cnt, w0);
    check(locked == 1'b0, "R3 inverted stream never locks", 64'(locked), 0);

    inject = 1'b0;
    n = 0;
    while (!locked && n < 200) begin @(negedge clk); n++; end
    check(locked == 1'b1, "R7 relock after corruption stops", 64'(locked), 1);
    e0 = err_cnt;
    repeat (100) @(negedge clk);
    check(err_cnt == e0, "R7 clean after relock", err_cnt, e0);

    check(rec_seen > 200, "R8 generator bits observed", 64'(rec_seen), 200);
    check(rec_bad == 0, "R8 generator recurrence and inversion", 64'(rec_bad), 0);
    finish_run();
  end
endmodule